// File: doc/BRIEF.md
# Windowed Replay Matcher

The matcher answers cache-line read requests from a pre-recorded list of expected accesses. Recorded (offset, data) pairs are pushed in ahead of time through a valid/ready fill port and kept in a small window ordered from oldest to youngest. Every accepted request is compared against all live window entries in the same cycle. On a hit, the recorded data of the oldest matching entry is sent out together with the request timestamp. On a miss, the whole request is diverted to a fallback read port, so the matcher never stalls waiting for a match.

The low `LW` bits of a request address are the offset within a core's region, and the upper bits select the core. Matching uses the offset only, so one recorded list can serve any core. The core number is carried to the hit output. Entries that are passed over by a match stay in the window so that reordered requests can still find them. Entries that are never requested leave the window only when room is needed for new fills.

Top module: `replay_window_matcher`

## Requirements
- R1: After reset no hit or miss output is valid, the window is empty and `fill_ready` is 1.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. Each accepted request produces exactly one pulse on `hit_valid` or on `miss_valid` in the following cycle. Neither output is valid in a cycle that follows no acceptance.
- R3: `req_ready` equals `out_ready`. A request presented while `out_ready` is low produces no output.
- R4: A request hits when its offset `req_addr[LW-1:0]` equals the offset of a live entry. The hit returns that entry's data on `hit_data` and `req_addr[AW-1:LW]` on `hit_core`.
- R5: When several live entries share the offset, the oldest filled one is returned, and the next request for that offset gets the next oldest.
- R6: A matched entry leaves the window at once. A repeated request for its offset misses unless another live entry holds that offset.
- R7: When a match is made, live entries older than the matched one stay in the window and are marked as skipped. A later request for one of them still hits.
- R8: A miss outputs the full request address on `miss_addr`.
- R9: The request timestamp appears unchanged on `hit_ts` or on `miss_ts`, whichever output carries that request.
- R10: When the window holds `W` entries and its oldest entry is not skipped, `fill_ready` is 0 and the offered fill is ignored. A later request for that offset misses.
- R11: When the window is full and its oldest entry is skipped, a fill is accepted and the oldest entry is retired. A later request for the retired offset misses.
- R12: A fill and a request accepted in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A recorded entry is offered |
| fill_addr | input | LW | Offset of the recorded entry |
| fill_data | input | DW | Data of the recorded entry |
| fill_ready | output | 1 | Window can take the offered entry |
| req_valid | input | 1 | A host read request is offered |
| req_addr | input | AW | Request address, core number in the upper bits |
| req_ts | input | TW | Arrival timestamp of the request |
| req_ready | output | 1 | Request can be accepted |
| out_ready | input | 1 | Delay stage takes the result in the next cycle |
| hit_valid | output | 1 | Matched result is valid |
| hit_data | output | DW | Recorded data of the matched entry |
| hit_core | output | AW-LW | Core number of the matched request |
| hit_ts | output | TW | Timestamp of the matched request |
| miss_valid | output | 1 | Diverted request is valid |
| miss_addr | output | AW | Address of the diverted request |
| miss_ts | output | TW | Timestamp of the diverted request |

## Verification
The assertions assume that a high `out_ready` means the delay stage takes whichever result appears in the next cycle, so results are one-cycle pulses and are never held. They also assume that reset is held for at least one clock before traffic starts. The bench drives `out_ready` as this promise and changes inputs only on the falling edge. Its random fills and requests draw offsets from a small set of 16, so duplicates, skips, retirements and misses all occur often, and a random `out_ready` also covers refused requests.

// File: rtl/replay_window_matcher.sv
module replay_window_matcher #(
  parameter int AW = 12,
  parameter int LW = 8,
  parameter int DW = 32,
  parameter int TW = 16,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_valid,
  input  logic [LW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  output logic          fill_ready,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [TW-1:0] req_ts,
  output logic          req_ready,
  input  logic          out_ready,
  output logic          hit_valid,
  output logic [DW-1:0] hit_data,
  output logic [AW-LW-1:0] hit_core,
  output logic [TW-1:0] hit_ts,
  output logic          miss_valid,
  output logic [AW-1:0] miss_addr,
  output logic [TW-1:0] miss_ts
);
  localparam int CW = $clog2(W + 1);

  logic [LW-1:0] a_q [W];
  logic [LW-1:0] a_n [W];
  logic [DW-1:0] d_q [W];
  logic [DW-1:0] d_n [W];
  logic [W-1:0]  s_q, s_n, match;
  logic [CW-1:0] cnt_q, cnt_n, m;
  logic [DW-1:0] sel_data;
  logic          acc, hit, fill_acc, retire;

  assign req_ready  = out_ready;
  assign acc        = req_valid && out_ready;
  assign fill_ready = (cnt_q < CW'(W)) || s_q[0];
  assign fill_acc   = fill_valid && fill_ready;

  always_comb begin
    match = '0;
    m = '0;
    sel_data = '0;
    for (int i = 0; i < W; i++)
      match[i] = (CW'(i) < cnt_q) && (a_q[i] == req_addr[LW-1:0]);
    for (int i = W - 1; i >= 0; i--)
      if (match[i]) begin
        m = CW'(i);
        sel_data = d_q[i];
      end
    hit    = acc && (|match);
    retire = fill_acc && (cnt_q == CW'(W)) && !hit;

    // remove the matched entry, marking everything older as skipped
    for (int i = 0; i < W; i++) begin
      if (hit && CW'(i) >= m) begin
        if (i < W - 1) begin
          a_n[i] = a_q[i+1];
          d_n[i] = d_q[i+1];
          s_n[i] = s_q[i+1];
        end else begin
          a_n[i] = '0;
          d_n[i] = '0;
          s_n[i] = 1'b0;
        end
      end else begin
        a_n[i] = a_q[i];
        d_n[i] = d_q[i];
        s_n[i] = s_q[i] | hit;
      end
    end
    cnt_n = cnt_q - CW'(hit);

    // make room by dropping the oldest (skipped) entry
    if (retire) begin
      for (int i = 0; i < W - 1; i++) begin
        a_n[i] = a_n[i+1];
        d_n[i] = d_n[i+1];
        s_n[i] = s_n[i+1];
      end
      a_n[W-1] = '0;
      d_n[W-1] = '0;
      s_n[W-1] = 1'b0;
      cnt_n = cnt_n - CW'(1);
    end

    for (int i = 0; i < W; i++)
      if (fill_acc && CW'(i) == cnt_n) begin
        a_n[i] = fill_addr;
        d_n[i] = fill_data;
        s_n[i] = 1'b0;
      end
    cnt_n = cnt_n + CW'(fill_acc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      s_q        <= '0;
      hit_valid  <= 1'b0;
      miss_valid <= 1'b0;
      hit_data   <= '0;
      hit_core   <= '0;
      hit_ts     <= '0;
      miss_addr  <= '0;
      miss_ts    <= '0;
      for (int i = 0; i < W; i++) begin
        a_q[i] <= '0;
        d_q[i] <= '0;
      end
    end else begin
      cnt_q      <= cnt_n;
      s_q        <= s_n;
      a_q        <= a_n;
      d_q        <= d_n;
      hit_valid  <= hit;
      miss_valid <= acc && !hit;
      if (acc) begin
        hit_data  <= sel_data;
        hit_core  <= req_addr[AW-1:LW];
        hit_ts    <= req_ts;
        miss_addr <= req_addr;
        miss_ts   <= req_ts;
      end
    end
  end

  p_one_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (hit_valid != miss_valid));
  p_no_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !hit_valid && !miss_valid);
  p_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !out_ready) |=> !hit_valid && !miss_valid);
  p_miss_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !(|match)) |=> miss_valid && miss_addr == $past(req_addr));
  p_ts_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((hit_valid ? hit_ts : miss_ts) == $past(req_ts)));
  p_full_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(W) && !s_q[0]) |-> !fill_ready);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(W));
  p_fill_grows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_acc && !acc && cnt_q < CW'(W)) |=> cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: tb/sim_replay_window_matcher.sv
`timescale 1ns/1ps
module sim_replay_window_matcher;
  localparam int AW = 12, LW = 8, DW = 32, TW = 16, W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fill_valid = 1'b0, req_valid = 1'b0, out_ready = 1'b0;
  logic [LW-1:0] fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_ts = '0;
  logic fill_ready, req_ready, hit_valid, miss_valid;
  logic [DW-1:0] hit_data;
  logic [AW-LW-1:0] hit_core;
  logic [TW-1:0] hit_ts, miss_ts;
  logic [AW-1:0] miss_addr;

  always #2.5 clk = ~clk;

  replay_window_matcher #(.AW(AW), .LW(LW), .DW(DW), .TW(TW), .W(W)) u0 (
    .clk, .rst_n, .fill_valid, .fill_addr, .fill_data, .fill_ready,
    .req_valid, .req_addr, .req_ts, .req_ready, .out_ready,
    .hit_valid, .hit_data, .hit_core, .hit_ts,
    .miss_valid, .miss_addr, .miss_ts);

  int errs = 0, checks = 0;
  logic [LW-1:0] ma [W];
  logic [DW-1:0] md [W];
  bit ms [W];
  int mc = 0;

  task automatic chk(input bit ok, input string msg, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic cyc(input bit fv, input logic [LW-1:0] fa, input logic [DW-1:0] fd,
                     input bit rv, input logic [AW-1:0] ra, input logic [TW-1:0] rt,
                     input bit ordy, input string tag);
    bit exp_fr, acc, facc;
    int k;
    logic [DW-1:0] ed;
    @(negedge clk);
    fill_valid = fv; fill_addr = fa; fill_data = fd;
    req_valid = rv; req_addr = ra; req_ts = rt; out_ready = ordy;
    #1;
    exp_fr = (mc < W) || ms[0];
    chk(fill_ready == exp_fr, "R10 fill_ready", fill_ready, exp_fr);
    chk(req_ready == ordy, "R3 req_ready", req_ready, ordy);
    acc = rv && ordy;
    facc = fv && exp_fr;
    k = -1;
    ed = '0;
    if (acc)
      for (int i = mc - 1; i >= 0; i--)
        if (ma[i] == ra[LW-1:0]) k = i;
    if (k >= 0) begin
      ed = md[k];
      for (int i = 0; i < k; i++) ms[i] = 1'b1;
      for (int i = k; i < mc - 1; i++) begin
        ma[i] = ma[i+1]; md[i] = md[i+1]; ms[i] = ms[i+1];
      end
      mc--;
    end
    if (facc && mc == W) begin
      for (int i = 0; i < W - 1; i++) begin
        ma[i] = ma[i+1]; md[i] = md[i+1]; ms[i] = ms[i+1];
      end
      mc--;
    end
    if (facc) begin
      ma[mc] = fa; md[mc] = fd; ms[mc] = 1'b0; mc++;
    end
    @(posedge clk);
    #1;
    if (acc && k >= 0) begin
      chk(hit_valid && !miss_valid, {tag, " R2 hit pulse"}, {hit_valid, miss_valid}, 2'b10);
      chk(hit_data == ed, {tag, " R4 hit_data"}, hit_data, ed);
      chk(hit_core == ra[AW-1:LW], "R4 hit_core", hit_core, ra[AW-1:LW]);
      chk(hit_ts == rt, "R9 hit_ts", hit_ts, rt);
    end else if (acc) begin
      chk(!hit_valid && miss_valid, {tag, " R2 miss pulse"}, {hit_valid, miss_valid}, 2'b01);
      chk(miss_addr == ra, "R8 miss_addr", miss_addr, ra);
      chk(miss_ts == rt, "R9 miss_ts", miss_ts, rt);
    end else begin
      chk(!hit_valid && !miss_valid, {tag, " R2 no output"}, {hit_valid, miss_valid}, 2'b00);
    end
  endtask

  task automatic fill(input logic [LW-1:0] fa, input logic [DW-1:0] fd, input string tag);
    cyc(1'b1, fa, fd, 1'b0, '0, '0, 1'b1, tag);
  endtask

  task automatic req(input logic [AW-1:0] ra, input logic [TW-1:0] rt, input string tag);
    cyc(1'b0, '0, '0, 1'b1, ra, rt, 1'b1, tag);
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(!hit_valid && !miss_valid, "R1 outputs idle in reset", {hit_valid, miss_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(fill_ready == 1'b1, "R1 fill_ready after reset", fill_ready, 1);
    chk(!hit_valid && !miss_valid, "R1 outputs idle after reset", {hit_valid, miss_valid}, 0);
    req(12'h310, 16'd1, "R1");

    // oldest wins among duplicates, matched entry freed
    fill(8'h10, 32'hD1, "R12");
    fill(8'h20, 32'hD2, "R12");
    fill(8'h10, 32'hD3, "R12");
    req(12'h310, 16'd100, "R5");
    req(12'h510, 16'd101, "R5");
    req(12'h110, 16'd102, "R6");

    // skipped entries stay matchable
    fill(8'h30, 32'hD4, "R7");
    fill(8'h40, 32'hD5, "R7");
    req(12'h240, 16'd200, "R7");
    req(12'h220, 16'd201, "R7");
    req(12'h230, 16'd202, "R7");

    // full window with no skipped entry refuses fills
    for (int i = 0; i < W; i++) fill(8'h50 + 8'(i), 32'hE0 + 32'(i), "R10");
    fill(8'h58, 32'hEF, "R10");
    req(12'h058, 16'd300, "R10");

    // skipped oldest is retired to make room
    req(12'h053, 16'd301, "R11");
    fill(8'h60, 32'hF0, "R11");
    fill(8'h61, 32'hF1, "R11");
    req(12'h050, 16'd302, "R11");

    // fill and match in one cycle
    cyc(1'b1, 8'h62, 32'hF2, 1'b1, 12'h751, 16'd400, 1'b1, "R12");
    req(12'h762, 16'd401, "R12");

    // refused request
    cyc(1'b0, '0, '0, 1'b1, 12'h761, 16'd500, 1'b0, "R3");
    req(12'h761, 16'd501, "R3");

    for (int n = 0; n < 3000; n++)
      cyc(($urandom % 3) != 0, 8'($urandom % 16), $urandom,
          ($urandom % 2) == 0, {4'($urandom), 8'($urandom % 16)}, 16'($urandom),
          ($urandom % 4) != 0, "R2");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule